// File: doc/BRIEF.md
# Coarse/Fine Black-Level Offset Trim Loop

This block closes the digital side of a black-level calibration loop. Each time a new black-level average arrives with its valid pulse, the block subtracts a programmed 8-bit target code from it. It then nudges a pair of DAC code registers so that the converter's effective output moves back toward the target. The pair is a 9-bit coarse code and a 10-bit fine code. A higher code on either register raises the effective ADC output, so a positive error lowers the codes and a negative error raises them.

Normal operation walks the fine code by one count per update, where one count is half an ADC LSB. When the fine code runs off either end, it is reloaded to midscale and the coarse code carries. A fast-convergence option replaces the fine step with a programmable coarse step when the error is large. A selectable dead band ignores small errors. Hold freezes both codes. Manual mode turns the loop off and lets software load each code directly.

The recommended configuration after reset is fast convergence on, dead band wide, hold off and manual off. Software drives these through the control inputs.

Top module: `offset_trim_loop`

## Requirements
- R1: After reset the coarse code is 256 and the fine code is 512 (both midscale).
- R2: The error is avgData minus targetCode. An update with a positive error lowers the fine code by exactly 1, and an update with a negative error raises it by exactly 1, unless R3 or R4 applies.
- R3: dnsSel selects the dead band: 0 = off (only an error of 0 is ignored), 1 = |error| ≤ 1, 2 = |error| ≤ 2, 3 = |error| ≤ 4. An error inside the band leaves both codes unchanged.
- R4: With fastEn = 1 and |error| > 128, the coarse code moves by crsStep and the fine code is unchanged. It moves down for a positive error and up for a negative one. With fastEn = 0 the fine step of R2 is always used.
- R5: A fine increment from 1023 reloads the fine code to 512 and raises the coarse code by 1. A fine decrement from 0 reloads it to 512 and lowers the coarse code by 1.
- R6: The coarse code saturates at 0 and 511 for both coarse steps and fine carries, and never wraps.
- R7: The codes change only at the clock edge that samples avgValid = 1 (or a manual write). They are stable otherwise.
- R8: While holdEn = 1, neither code changes, whether the cause is an update or a manual write.
- R9: With manualEn = 1 the loop makes no update. manCrsWr / manFinWr load manCrsVal / manFinVal at the next edge. With manualEn = 0 the manual writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| avgData | input | 12 | Black-level average |
| avgValid | input | 1 | One-cycle strobe: avgData is new |
| targetCode | input | 8 | Target black-level code |
| fastEn | input | 1 | Enable coarse steps on large error |
| dnsSel | input | 2 | Dead-band selection |
| holdEn | input | 1 | Freeze both codes |
| manualEn | input | 1 | Disable loop, enable direct writes |
| crsStep | input | 9 | Coarse step size in fast mode |
| manCrsWr | input | 1 | Manual coarse write strobe |
| manCrsVal | input | 9 | Manual coarse value |
| manFinWr | input | 1 | Manual fine write strobe |
| manFinVal | input | 10 | Manual fine value |
| crsCode | output | 9 | Coarse DAC code |
| finCode | output | 10 | Fine DAC code |

## Verification
The main sweep walks every error from -200 to +200 under all four dead-band settings, with fast mode on and off, at three target codes. This separates the band edges (errors of ±1, ±2, ±4, ±5), the fast threshold (±128 against ±129) and the step direction. Targeted cases preload the fine code at 0 and 1023 and the coarse code near its limits, to tell carry from saturation. Hold and manual cases then apply updates and writes and observe that the codes stay where the mode says they must.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef struct packed {
    logic finUp;
    logic finDn;
    logic crsUp;
    logic crsDn;
    logic crsLoad;
    logic finLoad;
  } trimStrobe_t;
endpackage

// File: rtl/trim_ctrl.sv
module trim_ctrl
  import trim_pkg::*;
#(
  parameter int AVG_W = 12,
  parameter int TGT_W = 8,
  parameter int NARROW_BAND = 1,
  parameter int MEDIUM_BAND = 2,
  parameter int WIDE_BAND = 4,
  parameter int FAST_LIMIT = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AVG_W-1:0] avgData,
  input  logic             avgValid,
  input  logic [TGT_W-1:0] targetCode,
  input  logic             fastEn,
  input  logic [1:0]       dnsSel,
  input  logic             holdEn,
  input  logic             manualEn,
  input  logic             manCrsWr,
  input  logic             manFinWr,
  output trimStrobe_t      strobe
);
  localparam int ERR_W = AVG_W + 2;

  logic signed [ERR_W-1:0] err;
  logic [ERR_W-1:0] absErr;
  logic [ERR_W-1:0] band;
  logic errNeg, inBand, bigErr, runLoop;

  always_comb begin
    err    = $signed(ERR_W'(avgData)) - $signed(ERR_W'(targetCode));
    errNeg = err[ERR_W-1];
    absErr = errNeg ? ERR_W'(-err) : ERR_W'(err);
    case (dnsSel)
      2'd1:    band = ERR_W'(NARROW_BAND);
      2'd2:    band = ERR_W'(MEDIUM_BAND);
      2'd3:    band = ERR_W'(WIDE_BAND);
      default: band = '0;
    endcase
    inBand  = absErr <= band;
    bigErr  = fastEn && (absErr > ERR_W'(FAST_LIMIT));
    runLoop = avgValid && !holdEn && !manualEn && !inBand;
    strobe.crsDn   = runLoop && bigErr && !errNeg;
    strobe.crsUp   = runLoop && bigErr && errNeg;
    strobe.finDn   = runLoop && !bigErr && !errNeg;
    strobe.finUp   = runLoop && !bigErr && errNeg;
    strobe.crsLoad = !holdEn && manualEn && manCrsWr;
    strobe.finLoad = !holdEn && manualEn && manFinWr;
  end

  AST_SINGLE_MOVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.finUp, strobe.finDn, strobe.crsUp, strobe.crsDn})); // R4
endmodule

// File: rtl/trim_dp.sv
module trim_dp
  import trim_pkg::*;
#(
  parameter int CRS_W = 9,
  parameter int FIN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  trimStrobe_t      strobe,
  input  logic [CRS_W-1:0] crsStep,
  input  logic [CRS_W-1:0] manCrsVal,
  input  logic [FIN_W-1:0] manFinVal,
  output logic [CRS_W-1:0] crsCode,
  output logic [FIN_W-1:0] finCode
);
  localparam logic [CRS_W-1:0] CRS_MAX = '1;
  localparam logic [CRS_W-1:0] CRS_MID = CRS_W'(1) << (CRS_W - 1);
  localparam logic [FIN_W-1:0] FIN_MAX = '1;
  localparam logic [FIN_W-1:0] FIN_MID = FIN_W'(1) << (FIN_W - 1);

  logic [CRS_W:0] crsSum;
  logic [CRS_W-1:0] crsStepUp, crsStepDn;

  always_comb begin
    crsSum    = {1'b0, crsCode} + {1'b0, crsStep};
    crsStepUp = crsSum[CRS_W] ? CRS_MAX : crsSum[CRS_W-1:0];
    crsStepDn = (crsStep > crsCode) ? '0 : crsCode - crsStep;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crsCode <= CRS_MID;
      finCode <= FIN_MID;
    end else begin
      if (strobe.crsLoad) crsCode <= manCrsVal;
      if (strobe.finLoad) finCode <= manFinVal;
      if (strobe.crsUp) crsCode <= crsStepUp;
      if (strobe.crsDn) crsCode <= crsStepDn;
      if (strobe.finUp) begin
        if (finCode == FIN_MAX) begin
          finCode <= FIN_MID;
          if (crsCode != CRS_MAX) crsCode <= crsCode + 1'b1;
        end else begin
          finCode <= finCode + 1'b1;
        end
      end
      if (strobe.finDn) begin
        if (finCode == '0) begin
          finCode <= FIN_MID;
          if (crsCode != '0) crsCode <= crsCode - 1'b1;
        end else begin
          finCode <= finCode - 1'b1;
        end
      end
    end
  end

  AST_FINE_STEP: assert property (@(posedge clk) disable iff (rst)
    (strobe.finUp && finCode != FIN_MAX) |=> finCode == FIN_W'($past(finCode) + 1'b1)); // R2
  AST_FINE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (strobe.finUp && finCode == FIN_MAX) |=>
      (finCode == FIN_MID && (crsCode == CRS_W'($past(crsCode) + 1'b1) || $past(crsCode) == CRS_MAX))); // R5
  AST_CRS_SAT_UP: assert property (@(posedge clk) disable iff (rst)
    strobe.crsUp |=> crsCode >= $past(crsCode)); // R6
  AST_CRS_SAT_DN: assert property (@(posedge clk) disable iff (rst)
    strobe.crsDn |=> crsCode <= $past(crsCode)); // R6
endmodule

// File: rtl/offset_trim_loop.sv
module offset_trim_loop
  import trim_pkg::*;
#(
  parameter int AVG_W = 12,
  parameter int TGT_W = 8,
  parameter int CRS_W = 9,
  parameter int FIN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AVG_W-1:0] avgData,
  input  logic             avgValid,
  input  logic [TGT_W-1:0] targetCode,
  input  logic             fastEn,
  input  logic [1:0]       dnsSel,
  input  logic             holdEn,
  input  logic             manualEn,
  input  logic [CRS_W-1:0] crsStep,
  input  logic             manCrsWr,
  input  logic [CRS_W-1:0] manCrsVal,
  input  logic             manFinWr,
  input  logic [FIN_W-1:0] manFinVal,
  output logic [CRS_W-1:0] crsCode,
  output logic [FIN_W-1:0] finCode
);
  trimStrobe_t strobe;

  trim_ctrl #(.AVG_W(AVG_W), .TGT_W(TGT_W)) u_ctrl (
    .clk(clk), .rst(rst), .avgData(avgData), .avgValid(avgValid),
    .targetCode(targetCode), .fastEn(fastEn), .dnsSel(dnsSel),
    .holdEn(holdEn), .manualEn(manualEn), .manCrsWr(manCrsWr),
    .manFinWr(manFinWr), .strobe(strobe)
  );

  trim_dp #(.CRS_W(CRS_W), .FIN_W(FIN_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .crsStep(crsStep),
    .manCrsVal(manCrsVal), .manFinVal(manFinVal),
    .crsCode(crsCode), .finCode(finCode)
  );

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    holdEn |=> ($stable(crsCode) && $stable(finCode))); // R8
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!avgValid && !manualEn) |=> ($stable(crsCode) && $stable(finCode))); // R7
  AST_MANUAL_NO_LOOP: assert property (@(posedge clk) disable iff (rst)
    (manualEn && !manFinWr) |=> $stable(finCode)); // R9
endmodule

// File: tb/offset_trim_loop_bench.sv
module offset_trim_loop_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] avgData = '0;
  logic avgValid = 1'b0;
  logic [7:0] targetCode = '0;
  logic fastEn = 1'b1;
  logic [1:0] dnsSel = 2'd3;
  logic holdEn = 1'b0;
  logic manualEn = 1'b0;
  logic [8:0] crsStep = 9'd37;
  logic manCrsWr = 1'b0;
  logic [8:0] manCrsVal = '0;
  logic manFinWr = 1'b0;
  logic [9:0] manFinVal = '0;
  logic [8:0] crsCode;
  logic [9:0] finCode;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  offset_trim_loop u_offset_trim_loop (
    .clk(clk), .rst(rst), .avgData(avgData), .avgValid(avgValid),
    .targetCode(targetCode), .fastEn(fastEn), .dnsSel(dnsSel),
    .holdEn(holdEn), .manualEn(manualEn), .crsStep(crsStep),
    .manCrsWr(manCrsWr), .manCrsVal(manCrsVal), .manFinWr(manFinWr),
    .manFinVal(manFinVal), .crsCode(crsCode), .finCode(finCode)
  );

  task automatic check(input string req, input int expC, input int expF);
    nChecks++;
    if (int'(crsCode) != expC || int'(finCode) != expF) begin
      nFails++;
      $display("FAIL %s: crs=%0d fin=%0d expected crs=%0d fin=%0d", req,
               crsCode, finCode, expC, expF);
    end
  endtask

  task automatic preload(input int c, input int f);
    @(negedge clk);
    manualEn = 1'b1; manCrsWr = 1'b1; manFinWr = 1'b1;
    manCrsVal = 9'(c); manFinVal = 10'(f);
    @(negedge clk);
    manCrsWr = 1'b0; manFinWr = 1'b0; manualEn = 1'b0;
  endtask

  task automatic pulse(input int avg);
    @(negedge clk);
    avgData = 12'(avg); avgValid = 1'b1;
    @(negedge clk);
    avgValid = 1'b0;
  endtask

  function automatic void model(input int c, input int f, input int e,
                                input bit fast, input int dns, input int step,
                                output int ec, output int ef);
    int band;
    int a;
    band = (dns == 0) ? 0 : (dns == 1) ? 1 : (dns == 2) ? 2 : 4;
    a = (e < 0) ? -e : e;
    ec = c; ef = f;
    if (a <= band) return;
    if (fast && a > 128) begin
      if (e > 0) ec = (c - step < 0) ? 0 : c - step;
      else       ec = (c + step > 511) ? 511 : c + step;
    end else if (e > 0) begin
      if (f == 0) begin ef = 512; ec = (c == 0) ? 0 : c - 1; end
      else ef = f - 1;
    end else begin
      if (f == 1023) begin ef = 512; ec = (c == 511) ? 511 : c + 1; end
      else ef = f + 1;
    end
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int ec, ef;
    int tgts[3] = '{0, 200, 255};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset midscale", 256, 512);

    // R7: no valid, no manual -> codes hold over several cycles
    avgData = 12'd400; targetCode = 8'd10;
    repeat (4) @(negedge clk);
    check("R7 idle stable", 256, 512);

    // R2 R3 R4 sweep
    for (int t = 0; t < 3; t++) begin
      for (int fm = 0; fm < 2; fm++) begin
        for (int d = 0; d < 4; d++) begin
          for (int e = -200; e <= 200; e++) begin
            if (tgts[t] + e < 0) continue;
            targetCode = 8'(tgts[t]); fastEn = fm[0]; dnsSel = 2'(d); crsStep = 9'd37;
            preload(256, 512);
            pulse(tgts[t] + e);
            model(256, 512, e, fm[0], d, 37, ec, ef);
            check("R2/R3/R4 sweep", ec, ef);
          end
        end
      end
    end

    // R5 fine carry
    targetCode = 8'd100; dnsSel = 2'd0; fastEn = 1'b1;
    preload(300, 1023); pulse(90);
    check("R5 fine overflow carry", 301, 512);
    preload(300, 0); pulse(110);
    check("R5 fine underflow borrow", 299, 512);

    // R6 saturation
    preload(511, 1023); pulse(90);
    check("R6 carry saturates at 511", 511, 512);
    preload(0, 0); pulse(110);
    check("R6 borrow saturates at 0", 0, 512);
    crsStep = 9'd20;
    preload(5, 400); pulse(250);
    check("R6 coarse step floor 0", 0, 400);
    targetCode = 8'd200;
    preload(500, 400); pulse(50);
    check("R6 coarse step ceiling 511", 511, 400);

    // R8 hold
    preload(123, 456);
    holdEn = 1'b1;
    pulse(0);
    check("R8 hold blocks update", 123, 456);
    @(negedge clk);
    manualEn = 1'b1; manCrsWr = 1'b1; manFinWr = 1'b1; manCrsVal = 9'd7; manFinVal = 10'd9;
    @(negedge clk);
    manCrsWr = 1'b0; manFinWr = 1'b0; manualEn = 1'b0;
    check("R8 hold blocks manual write", 123, 456);
    holdEn = 1'b0;

    // R9 manual
    @(negedge clk);
    manCrsWr = 1'b1; manFinWr = 1'b1; manCrsVal = 9'd7; manFinVal = 10'd9;
    @(negedge clk);
    manCrsWr = 1'b0; manFinWr = 1'b0;
    check("R9 write ignored without manual", 123, 456);
    preload(77, 88);
    check("R9 manual load", 77, 88);
    manualEn = 1'b1;
    pulse(0);
    check("R9 loop off in manual", 77, 88);
    @(negedge clk);
    manFinWr = 1'b1; manFinVal = 10'd1000;
    @(negedge clk);
    manFinWr = 1'b0; manualEn = 1'b0;
    check("R9 fine-only write", 77, 1000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule